// File: doc/BRIEF.md
# In-Order Completion Reorder Buffer

This block keeps a ring of sixteen slots that follow each instruction from the moment it is dispatched until it becomes architectural. Dispatch claims up to four consecutive slots per cycle in program order, and each claimed slot's tag is handed back to the front end. Execution units later report a tag as done, optionally with a fault flag. Branches are only considered done when the branch unit resolves them. A resolution that reveals a wrong guess throws away every slot younger than the branch.

The completion side examines the oldest four slots every cycle. It retires the longest in-order run of done entries whose destination writes still fit the register-file write ports: two integer and two floating-point per cycle. The retiring tags and their write kinds are presented as registered outputs for the writeback stage. A faulting entry halts completion. Once that entry is the oldest, it is reported with its tag, and it is discarded along with everything behind it.

Top module: `rob_core`

## Requirements
- R1: The buffer holds DEPTH (16) slots. A dispatch group of n receives tags `disp_tag_base`, `disp_tag_base+1`, … `disp_tag_base+n-1` modulo 16, and occupancy never exceeds 16.
- R2: `disp_valid` must be a contiguous run from bit 0. `disp_ok` is high only when the free slots cover the whole requested group and no flush is occurring this cycle. A refused group claims nothing, so `disp_tag_base` is unchanged afterwards.
- R3: A finish report (`fin_valid`/`fin_tag`) marks an in-flight non-branch slot done. A report naming a tag that is not in flight is ignored. A report naming a branch slot is also ignored.
- R4: Completion retires strictly from the oldest slot, up to four per cycle, with `ret_valid` always a contiguous run from bit 0. Retire outputs appear at the earliest one clock edge after the edge that captured the last needed finish.
- R5: Write kind per slot is encoded 0 = none, 1 = integer, 2 = floating point. At most two integer and two floating-point entries retire per cycle. Kind 0 entries are not port-limited, and the retire run stops at the first entry that would exceed a budget.
- R6: A slot dispatched with `disp_br` set becomes done only through `br_valid` with its tag. Finished younger slots do not retire while it is unresolved.
- R7: A resolution with `br_mispredict` set discards every slot younger than `br_tag` while keeping the branch, so the next dispatch tag is `br_tag+1`. A group offered in that cycle is refused.
- R8: A slot finished with `fin_exc` set halts completion at itself. When it is the oldest, `exc_valid` pulses for one cycle with `exc_tag` equal to its tag. No entry retires in that output cycle, the faulting slot and all younger ones are discarded, and the next dispatch tag equals the faulting tag.
- R9: After reset `ret_valid` and `exc_valid` are low, the buffer is empty, `disp_tag_base` is 0 and a four-wide group is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| disp_valid | input | 4 | Dispatch lanes requested, contiguous from bit 0 |
| disp_kind | input | 8 | Per-lane write kind, 2 bits per lane |
| disp_br | input | 4 | Per-lane branch marker |
| disp_ok | output | 1 | Whole group accepted this cycle |
| disp_tag_base | output | 4 | Tag given to lane 0 |
| fin_valid | input | 4 | Finish report valid per port |
| fin_tag | input | 16 | Finish tag, 4 bits per port |
| fin_exc | input | 4 | Finish carries a fault |
| br_valid | input | 1 | Branch resolution valid |
| br_tag | input | 4 | Tag of the resolved branch |
| br_mispredict | input | 1 | Resolution disagrees with the guess |
| ret_valid | output | 4 | Retiring lanes, contiguous from bit 0 |
| ret_tag | output | 16 | Retiring tags, 4 bits per lane |
| ret_kind | output | 8 | Retiring write kinds, 2 bits per lane |
| exc_valid | output | 1 | Fault reported for the oldest slot |
| exc_tag | output | 4 | Tag of the faulting slot |

## Verification
The hardest situations to reach are those where completion is held back even though slots are done. These are a done entry waiting behind an unresolved branch, a run cut short by the write-port budget, and a fault sitting behind a retirable entry. The stimulus reaches them by finishing younger tags first, sometimes through several finish ports in one cycle, and only then releasing the blocker. It also drives a four-port finish so that a mixed-kind group leaves in a single cycle. Wrap-around is covered by filling the ring to sixteen across the tag boundary. A squashed tag is then re-issued, and the bench confirms that stale done state does not leak into the new slot.

// File: rtl/rob_pkg.sv
package rob_pkg;
  typedef enum logic [1:0] {
    WK_NONE = 2'd0,
    WK_INT  = 2'd1,
    WK_FP   = 2'd2
  } wr_kind_e;
endpackage

// File: rtl/rob_alloc_ctl.sv
// Whole-group dispatch admission against the registered occupancy.
module rob_alloc_ctl #(
  parameter int DEPTH  = 16,
  parameter int DISP_W = 4,
  localparam int PTR_W = $clog2(DEPTH) + 1,
  localparam int CNT_W = $clog2(DISP_W + 1)
) (
  input  logic [DISP_W-1:0] req,
  input  logic [PTR_W-1:0]  occ,
  input  logic              block,
  output logic              ok,
  output logic [CNT_W-1:0]  n_alloc
);
  logic [CNT_W-1:0] n_req;
  logic [PTR_W-1:0] free_slots;

  always_comb begin
    n_req      = CNT_W'($countones(req));
    free_slots = PTR_W'(DEPTH) - occ;
    ok         = !block && (PTR_W'(n_req) <= free_slots);
    n_alloc    = ok ? n_req : '0;
  end
endmodule

// File: rtl/rob_retire_pick.sv
// Chooses the in-order run of oldest entries that may retire this cycle.
module rob_retire_pick #(
  parameter int RET_W  = 4,
  parameter int INT_WP = 2,
  parameter int FP_WP  = 2,
  localparam int CNT_W = $clog2(RET_W + 1)
) (
  input  logic [RET_W-1:0]   live,
  input  logic [RET_W-1:0]   ready,
  input  logic [2*RET_W-1:0] kind,
  output logic [RET_W-1:0]   take,
  output logic [CNT_W-1:0]   n_take
);
  import rob_pkg::*;

  always_comb begin
    logic [CNT_W-1:0] c_int;
    logic [CNT_W-1:0] c_fp;
    logic             stop;
    logic [1:0]       k;
    c_int  = '0;
    c_fp   = '0;
    stop   = 1'b0;
    take   = '0;
    n_take = '0;
    for (int i = 0; i < RET_W; i++) begin
      k = kind[2*i +: 2];
      if (!stop && live[i] && ready[i] &&
          !(k == WK_INT && c_int >= CNT_W'(INT_WP)) &&
          !(k == WK_FP  && c_fp  >= CNT_W'(FP_WP))) begin
        take[i] = 1'b1;
        n_take  = n_take + 1'b1;
        if (k == WK_INT) c_int = c_int + 1'b1;
        if (k == WK_FP)  c_fp  = c_fp + 1'b1;
      end else begin
        stop = 1'b1;
      end
    end
  end

  // R4: the chosen lanes always form a run starting at the oldest lane
  always_comb begin
    assert_pick_run_R4: assert ((take & (take + 1'b1)) == '0);
  end
endmodule

// File: rtl/rob_core.sv
module rob_core #(
  parameter int DEPTH  = 16,
  parameter int DISP_W = 4,
  parameter int RET_W  = 4,
  parameter int FIN_N  = 4,
  parameter int INT_WP = 2,
  parameter int FP_WP  = 2,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int PTR_W = IDX_W + 1
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [DISP_W-1:0]      disp_valid,
  input  logic [2*DISP_W-1:0]    disp_kind,
  input  logic [DISP_W-1:0]      disp_br,
  output logic                   disp_ok,
  output logic [IDX_W-1:0]       disp_tag_base,
  input  logic [FIN_N-1:0]       fin_valid,
  input  logic [FIN_N*IDX_W-1:0] fin_tag,
  input  logic [FIN_N-1:0]       fin_exc,
  input  logic                   br_valid,
  input  logic [IDX_W-1:0]       br_tag,
  input  logic                   br_mispredict,
  output logic [RET_W-1:0]       ret_valid,
  output logic [RET_W*IDX_W-1:0] ret_tag,
  output logic [2*RET_W-1:0]     ret_kind,
  output logic                   exc_valid,
  output logic [IDX_W-1:0]       exc_tag
);
  import rob_pkg::*;

  localparam int DCNT_W = $clog2(DISP_W + 1);
  localparam int RCNT_W = $clog2(RET_W + 1);

  // Pointers carry one extra wrap bit; occupancy is their difference.
  logic [PTR_W-1:0] head_q, tail_q, head_d, tail_d, occ;

  // Per-slot state. Slot arrays are written with no reset; a slot is
  // cleared when it is claimed, and liveness comes from the pointers.
  logic       done_q [DEPTH];
  logic       fault_q[DEPTH];
  logic       isbr_q [DEPTH];
  logic [1:0] kind_q [DEPTH];

  logic [IDX_W-1:0]     head_idx, tail_idx;
  logic [RET_W-1:0]     win_live, win_ready, take;
  logic [2*RET_W-1:0]   win_kind;
  logic [RET_W*IDX_W-1:0] win_tag;
  logic [RCNT_W-1:0]    n_take;
  logic [DCNT_W-1:0]    n_alloc;
  logic                 flush_all, squash, alloc_ok;
  logic [IDX_W-1:0]     br_off;

  assign occ      = tail_q - head_q;
  assign head_idx = head_q[IDX_W-1:0];
  assign tail_idx = tail_q[IDX_W-1:0];
  assign disp_tag_base = tail_idx;

  function automatic logic in_flight(input logic [IDX_W-1:0] tag,
                                     input logic [IDX_W-1:0] hidx,
                                     input logic [PTR_W-1:0] cnt);
    logic [IDX_W-1:0] off;
    off = tag - hidx;
    return ({1'b0, off} < cnt);
  endfunction

  // Window of the oldest RET_W slots
  always_comb begin
    for (int i = 0; i < RET_W; i++) begin
      logic [IDX_W-1:0] idx;
      idx                       = head_idx + IDX_W'(i);
      win_live[i]               = PTR_W'(i) < occ;
      win_ready[i]              = done_q[idx] && !fault_q[idx];
      win_kind[2*i +: 2]        = kind_q[idx];
      win_tag[IDX_W*i +: IDX_W] = idx;
    end
  end

  // The oldest slot is done and faulted: report it and drop everything.
  assign flush_all = (occ != '0) && done_q[head_idx] && fault_q[head_idx];
  assign squash    = br_valid && br_mispredict && !flush_all;
  assign br_off    = br_tag - head_idx;

  rob_alloc_ctl #(.DEPTH(DEPTH), .DISP_W(DISP_W)) u_alloc (
    .req     (disp_valid),
    .occ     (occ),
    .block   (flush_all || (br_valid && br_mispredict)),
    .ok      (alloc_ok),
    .n_alloc (n_alloc)
  );
  assign disp_ok = alloc_ok;

  rob_retire_pick #(.RET_W(RET_W), .INT_WP(INT_WP), .FP_WP(FP_WP)) u_pick (
    .live   (win_live),
    .ready  (win_ready),
    .kind   (win_kind),
    .take   (take),
    .n_take (n_take)
  );

  always_comb begin
    head_d = head_q + PTR_W'(n_take);
    if (flush_all)
      tail_d = head_q;
    else if (squash)
      tail_d = head_q + PTR_W'(br_off) + PTR_W'(1);
    else
      tail_d = tail_q + PTR_W'(n_alloc);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      head_q    <= '0;
      tail_q    <= '0;
      ret_valid <= '0;
      ret_tag   <= '0;
      ret_kind  <= '0;
      exc_valid <= 1'b0;
      exc_tag   <= '0;
    end else begin
      head_q    <= head_d;
      tail_q    <= tail_d;
      ret_valid <= take;
      ret_tag   <= win_tag;
      ret_kind  <= win_kind;
      exc_valid <= flush_all;
      exc_tag   <= head_idx;
    end
  end

  // Slot state: finish reports, branch resolution, then allocation.
  always_ff @(posedge clk) begin
    for (int p = 0; p < FIN_N; p++) begin
      logic [IDX_W-1:0] ft;
      ft = fin_tag[IDX_W*p +: IDX_W];
      if (fin_valid[p] && in_flight(ft, head_idx, occ) && !isbr_q[ft]) begin
        done_q[ft]  <= 1'b1;
        fault_q[ft] <= fin_exc[p];
      end
    end
    if (br_valid && in_flight(br_tag, head_idx, occ) && isbr_q[br_tag])
      done_q[br_tag] <= 1'b1;
    for (int i = 0; i < DISP_W; i++) begin
      if (DCNT_W'(i) < n_alloc) begin
        done_q[tail_idx + IDX_W'(i)]  <= 1'b0;
        fault_q[tail_idx + IDX_W'(i)] <= 1'b0;
        isbr_q[tail_idx + IDX_W'(i)]  <= disp_br[i];
        kind_q[tail_idx + IDX_W'(i)]  <= disp_kind[2*i +: 2];
      end
    end
  end

  // Assertion helpers on the registered retire outputs
  logic [RCNT_W-1:0] ret_int_n, ret_fp_n;
  always_comb begin
    ret_int_n = '0;
    ret_fp_n  = '0;
    for (int i = 0; i < RET_W; i++) begin
      if (ret_valid[i] && ret_kind[2*i +: 2] == WK_INT) ret_int_n = ret_int_n + 1'b1;
      if (ret_valid[i] && ret_kind[2*i +: 2] == WK_FP)  ret_fp_n  = ret_fp_n + 1'b1;
    end
  end

  assert_no_overflow_R1: assert property (@(posedge clk) disable iff (rst)
    occ <= PTR_W'(DEPTH));
  assert_ret_run_R4: assert property (@(posedge clk) disable iff (rst)
    (ret_valid & (ret_valid + 1'b1)) == '0);
  assert_int_ports_R5: assert property (@(posedge clk) disable iff (rst)
    ret_int_n <= RCNT_W'(INT_WP));
  assert_fp_ports_R5: assert property (@(posedge clk) disable iff (rst)
    ret_fp_n <= RCNT_W'(FP_WP));
  assert_exc_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    exc_valid |-> (ret_valid == '0));
  assert_exc_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    exc_valid |=> !exc_valid);
endmodule

// File: tb/test_rob_core.sv
`timescale 1ns/100ps
module test_rob_core;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  disp_valid = '0;
  logic [7:0]  disp_kind = '0;
  logic [3:0]  disp_br = '0;
  logic        disp_ok;
  logic [3:0]  disp_tag_base;
  logic [3:0]  fin_valid = '0;
  logic [15:0] fin_tag = '0;
  logic [3:0]  fin_exc = '0;
  logic        br_valid = 1'b0;
  logic [3:0]  br_tag = '0;
  logic        br_mispredict = 1'b0;
  logic [3:0]  ret_valid;
  logic [15:0] ret_tag;
  logic [7:0]  ret_kind;
  logic        exc_valid;
  logic [3:0]  exc_tag;

  int checks = 0, errors = 0;
  int ret_total = 0, max_ret = 0, max_int = 0, exc_cycles = 0;
  int last_exc = -1;
  int exp_q[$];   // expected {kind, tag} as kind*16+tag

  always #2.5 clk = ~clk;

  rob_core i_rob_core (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic expect_ret(input int tag, input int kind);
    exp_q.push_back(kind * 16 + (tag & 15));
  endtask

  // Monitor / scoreboard
  always @(negedge clk) begin
    if (!rst) begin
      int n, ni, nf;
      n = 0; ni = 0; nf = 0;
      for (int i = 0; i < 4; i++) begin
        if (ret_valid[i]) begin
          int got;
          n++;
          got = int'(ret_kind[2*i +: 2]) * 16 + int'(ret_tag[4*i +: 4]);
          if (ret_kind[2*i +: 2] == 2'd1) ni++;
          if (ret_kind[2*i +: 2] == 2'd2) nf++;
          if (exp_q.size() == 0) chk(0, "R4 unexpected retire", got, -1);
          else begin
            int e;
            e = exp_q.pop_front();
            chk(got == e, "R4 retire order/kind", got, e);
          end
        end
      end
      if (ret_valid != 4'd0)
        chk(((ret_valid & (ret_valid + 4'd1)) == 4'd0), "R4 contiguous lanes", ret_valid, 0);
      if (ni > 2 || nf > 2) chk(0, "R5 port budget", ni * 10 + nf, 22);
      ret_total += n;
      if (n > max_ret) max_ret = n;
      if (ni > max_int) max_int = ni;
      if (exc_valid) begin
        exc_cycles++;
        last_exc = exc_tag;
        chk(ret_valid == 4'd0, "R8 no retire with fault", ret_valid, 0);
      end
    end
  end

  task automatic disp(input int n, input logic [7:0] kinds, input logic [3:0] brs,
                      input bit exp_ok, input int exp_base, input string req);
    @(negedge clk);
    disp_valid = 4'((1 << n) - 1);
    disp_kind  = kinds;
    disp_br    = brs;
    #0.5;
    chk(disp_ok == exp_ok, {req, " dispatch accept"}, disp_ok, exp_ok);
    chk(disp_tag_base == 4'(exp_base), {req, " dispatch tag"}, disp_tag_base, exp_base & 15);
    @(posedge clk);
    #0.5;
    disp_valid = '0; disp_kind = '0; disp_br = '0;
  endtask

  task automatic fin4(input logic [3:0] v, input int t0, input int t1,
                      input int t2, input int t3, input logic [3:0] ex);
    @(negedge clk);
    fin_valid = v;
    fin_tag   = {4'(t3), 4'(t2), 4'(t1), 4'(t0)};
    fin_exc   = ex;
    @(posedge clk);
    #0.5;
    fin_valid = '0; fin_exc = '0;
  endtask

  task automatic resolve(input int tag, input bit misp);
    @(negedge clk);
    br_valid = 1'b1; br_tag = 4'(tag); br_mispredict = misp;
    @(posedge clk);
    #0.5;
    br_valid = 1'b0; br_mispredict = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int snap;
    repeat (3) @(posedge clk);
    #0.5 rst = 1'b0;
    @(negedge clk);
    // R9 reset state
    chk(ret_valid == 0, "R9 ret_valid", ret_valid, 0);
    chk(exc_valid == 0, "R9 exc_valid", exc_valid, 0);
    chk(disp_tag_base == 0, "R9 tag base", disp_tag_base, 0);

    // R4/R5: four integer ops finished out of order, two int ports
    for (int t = 0; t < 4; t++) expect_ret(t, 1);
    disp(4, 8'h55, 4'h0, 1, 0, "R9");
    fin4(4'b0011, 3, 1, 0, 0, 4'h0);
    idle(3);
    chk(ret_total == 0, "R4 younger wait for oldest", ret_total, 0);
    fin4(4'b0011, 0, 2, 0, 0, 4'h0);
    idle(4);
    chk(ret_total == 4, "R4 all retired", ret_total, 4);
    chk(max_int == 2, "R5 int budget caps run", max_int, 2);
    chk(max_ret == 2, "R5 run split in two", max_ret, 2);

    // R4: mixed kinds leave four in one cycle
    expect_ret(4, 0); expect_ret(5, 1); expect_ret(6, 2); expect_ret(7, 0);
    disp(4, 8'h24, 4'h0, 1, 4, "R1");
    fin4(4'b1111, 7, 5, 4, 6, 4'h0);
    idle(4);
    chk(max_ret == 4, "R4 four-wide retire", max_ret, 4);

    // R1/R2: fill across wrap, whole-group refusal
    disp(4, 8'h00, 4'h0, 1, 8, "R1");
    disp(4, 8'h00, 4'h0, 1, 12, "R1");
    disp(4, 8'h00, 4'h0, 1, 0, "R1");
    disp(2, 8'h00, 4'h0, 1, 4, "R1");
    disp(4, 8'h00, 4'h0, 0, 6, "R2");
    disp(2, 8'h00, 4'h0, 1, 6, "R2");
    disp(1, 8'h00, 4'h0, 0, 8, "R2");
    @(negedge clk);
    chk(disp_tag_base == 8, "R2 refused group claims nothing", disp_tag_base, 8);
    for (int t = 8; t < 24; t++) expect_ret(t, 0);
    fin4(4'b1111, 8, 9, 10, 11, 4'h0);
    fin4(4'b1111, 12, 13, 14, 15, 4'h0);
    fin4(4'b1111, 0, 1, 2, 3, 4'h0);
    fin4(4'b1111, 4, 5, 6, 7, 4'h0);
    idle(5);
    chk(ret_total == 24, "R1 full ring drained", ret_total, 24);

    // R6: younger done entries wait for branch resolution
    disp(1, 8'h00, 4'h1, 1, 8, "R6");
    disp(2, 8'h05, 4'h0, 1, 9, "R6");
    fin4(4'b0011, 9, 10, 0, 0, 4'h0);
    idle(4);
    chk(ret_total == 24, "R6 blocked by branch", ret_total, 24);
    fin4(4'b0001, 8, 0, 0, 0, 4'h0);
    idle(3);
    chk(ret_total == 24, "R3 finish on branch ignored", ret_total, 24);
    expect_ret(8, 0); expect_ret(9, 1); expect_ret(10, 1);
    resolve(8, 0);
    idle(3);
    chk(ret_total == 27, "R6 released after resolve", ret_total, 27);

    // R7: mispredict squashes younger, same-cycle dispatch refused
    disp(1, 8'h00, 4'h1, 1, 11, "R7");
    disp(3, 8'h15, 4'h0, 1, 12, "R7");
    fin4(4'b0011, 12, 13, 0, 0, 4'h0);
    expect_ret(11, 0);
    @(negedge clk);
    br_valid = 1'b1; br_tag = 4'd11; br_mispredict = 1'b1;
    disp_valid = 4'b0001;
    #0.5;
    chk(disp_ok == 0, "R7 dispatch refused during squash", disp_ok, 0);
    @(posedge clk);
    #0.5;
    br_valid = 1'b0; br_mispredict = 1'b0; disp_valid = '0;
    idle(4);
    chk(disp_tag_base == 12, "R7 next tag after branch", disp_tag_base, 12);
    chk(ret_total == 28, "R7 squashed never retire", ret_total, 28);
    disp(1, 8'h01, 4'h0, 1, 12, "R7");
    idle(3);
    chk(ret_total == 28, "R7 reissued slot not stale-done", ret_total, 28);
    expect_ret(12, 1);
    fin4(4'b0001, 12, 0, 0, 0, 4'h0);
    idle(3);
    chk(ret_total == 29, "R7 reissued slot retires", ret_total, 29);

    // R8: fault halts completion and flushes
    disp(3, 8'h15, 4'h0, 1, 13, "R8");
    expect_ret(13, 1);
    fin4(4'b0111, 13, 15, 14, 0, 4'b0100);
    idle(5);
    chk(exc_cycles == 1, "R8 single fault pulse", exc_cycles, 1);
    chk(last_exc == 14, "R8 fault tag", last_exc, 14);
    chk(ret_total == 30, "R8 younger than fault dropped", ret_total, 30);
    chk(disp_tag_base == 14, "R8 next tag is fault tag", disp_tag_base, 14);

    // R3: finish for a tag not in flight is ignored
    fin4(4'b0001, 14, 0, 0, 0, 4'h0);
    disp(1, 8'h00, 4'h0, 1, 14, "R3");
    idle(4);
    chk(ret_total == 30, "R3 stale finish ignored", ret_total, 30);
    expect_ret(14, 0);
    fin4(4'b0001, 14, 0, 0, 0, 4'h0);
    idle(3);
    chk(ret_total == 31, "R3 real finish retires", ret_total, 31);
    chk(exp_q.size() == 0, "R4 scoreboard drained", exp_q.size(), 0);

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule